// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the state changes a processor's system-control coprocessor makes when it accepts an exception. Each cycle it may take one request. A request gives the fault type, a load/store flag, the faulting virtual address, the PC of the faulting instruction, an address-space identifier, a virtual page number and a coprocessor number. Fault prioritization happens upstream, so at most one request arrives per cycle.

From the current configuration and state, the block works out two things. The first is the handler address: a base plus an offset chosen by fault type and state. The second is the 5-bit exception code. In the same clock it updates the captured-address, translation-entry-high, page-context and cause registers, records the PC, and sets the exception-level flag. A one-cycle redirect pulse carries the handler address to instruction fetch.

The register state is visible on output ports so that neighbouring logic can read it. The block does not clear the exception-level flag, because returning from an exception is handled elsewhere. Only reset clears it.

Top module: `cp0_exc_entry`

## Requirements
- R1: After reset, `redirect_valid`, `status_exl` and every register output read zero.
- R2: The handler base is `cfg_ebase` when `cfg_bev` is 0 and the constant 0xBFC00200 when `cfg_bev` is 1. The vector is the base plus the offset.
- R3: An interrupt (type 0) uses offset 0x200 when `cfg_iv` is 1 and offset 0x180 when it is 0.
- R4: A TLB refill (type 2) uses offset 0x000 while `status_exl` is 0 and offset 0x180 while it is already 1.
- R5: Every other type uses offset 0x180.
- R6: The exception code per type is as follows: 0 interrupt→0, 5 syscall→8, 6 breakpoint→9, 7 reserved instruction→10, 8 coprocessor unusable→11, 9 overflow→12, 10 trap→13, 11 machine check→24, 12 thread→25, 13 instruction bus error→6, 14 data bus error→7, 15 watch→23.
- R7: Address error (type 1) reports 5 for a store and 4 for a load. TLB refill (2) and TLB invalid (3) report 3 for a store and 2 for a load. TLB modified (4) always reports 1, whatever `req_store` is.
- R8: Address error and the three TLB types (1 to 4) load `badvaddr` with `req_vaddr`. No other type changes it.
- R9: TLB types 2 to 4 load `entryhi_asid` with `req_asid`, `entryhi_vpn2` and `context_badvpn2` with `req_vpn` shifted right by two, and `entryhi_vpn2x` with `req_vpn[1:0]`. Other types leave these fields unchanged.
- R10: Coprocessor unusable (type 8) loads `cause_ce` with `req_cop`. Other types leave it unchanged.
- R11: The edge that accepts a request loads `cause_exccode`, `epc` with `req_pc`, and sets `status_exl`. The cycle after it shows `redirect_valid` high for that cycle only, with the vector on `redirect_vec`.
- R12: Without a request, no register output changes and `redirect_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request this cycle |
| req_type | input | 4 | Fault type encoding (see R3 to R10) |
| req_store | input | 1 | 1 for a store access, 0 for a load |
| req_vaddr | input | ADDR_W | Faulting virtual address |
| req_pc | input | ADDR_W | PC of the faulting instruction |
| req_asid | input | ASID_W | Address-space identifier |
| req_vpn | input | VPN_W | Virtual page number |
| req_cop | input | CP_W | Coprocessor number for unusable faults |
| cfg_bev | input | 1 | Boot vector select |
| cfg_ebase | input | ADDR_W | Programmable handler base |
| cfg_iv | input | 1 | Dedicated interrupt vector enable |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_vec | output | ADDR_W | Handler address |
| badvaddr | output | ADDR_W | Captured faulting address |
| entryhi_asid | output | ASID_W | Entry-high identifier field |
| entryhi_vpn2 | output | VPN_W-2 | Entry-high page-pair field |
| entryhi_vpn2x | output | 2 | Entry-high low page bits |
| context_badvpn2 | output | VPN_W-2 | Context page-pair field |
| cause_exccode | output | 5 | Exception code |
| cause_ce | output | CP_W | Coprocessor number of last unusable fault |
| status_exl | output | 1 | Exception level flag |
| epc | output | ADDR_W | Exception PC |

## Verification
A wrong exception-level flag appears only through the refill vector. A second refill after an accepted exception must land 0x180 higher, so the error shows one request later. A wrong decode of type or store flag shows in `cause_exccode` and `redirect_vec` in the cycle right after the request. Register fields that a fault type should leave alone can hold a stale error without any sign until some later request reads them back. For that reason each update is followed by an unrelated fault, and the outputs are compared then.

// File: rtl/cp0_exc_pkg.sv
package cp0_exc_pkg;

    typedef enum logic [3:0] {
        FT_INTR     = 4'd0,
        FT_ADDR     = 4'd1,
        FT_TLB_REF  = 4'd2,
        FT_TLB_INV  = 4'd3,
        FT_TLB_MOD  = 4'd4,
        FT_SYSCALL  = 4'd5,
        FT_BREAK    = 4'd6,
        FT_RSVD     = 4'd7,
        FT_COP_UNU  = 4'd8,
        FT_OVFL     = 4'd9,
        FT_TRAP     = 4'd10,
        FT_MCHK     = 4'd11,
        FT_THREAD   = 4'd12,
        FT_IBUS     = 4'd13,
        FT_DBUS     = 4'd14,
        FT_WATCH    = 4'd15
    } fault_e;

    typedef enum logic [1:0] {
        OFS_GENERAL = 2'd0,
        OFS_INTR    = 2'd1,
        OFS_REFILL  = 2'd2
    } ofs_class_e;

    localparam int CODE_W = 5;

endpackage

// File: rtl/cp0_exc_decode.sv
module cp0_exc_decode
    import cp0_exc_pkg::*;
(
    input  logic [3:0]        fault_type,
    input  logic              is_store,
    output logic [CODE_W-1:0] code,
    output ofs_class_e        ofs_class,
    output logic              wr_badva,
    output logic              wr_tlb,
    output logic              wr_ce
);
    fault_e ft;

    always_comb begin
        ft        = fault_e'(fault_type);
        code      = '0;
        ofs_class = OFS_GENERAL;
        wr_badva  = 1'b0;
        wr_tlb    = 1'b0;
        wr_ce     = 1'b0;
        unique case (ft)
            FT_INTR: begin
                code      = 5'd0;
                ofs_class = OFS_INTR;
            end
            FT_ADDR: begin
                code     = is_store ? 5'd5 : 5'd4;
                wr_badva = 1'b1;
            end
            FT_TLB_REF: begin
                code      = is_store ? 5'd3 : 5'd2;
                ofs_class = OFS_REFILL;
                wr_badva  = 1'b1;
                wr_tlb    = 1'b1;
            end
            FT_TLB_INV: begin
                code     = is_store ? 5'd3 : 5'd2;
                wr_badva = 1'b1;
                wr_tlb   = 1'b1;
            end
            FT_TLB_MOD: begin
                code     = 5'd1;
                wr_badva = 1'b1;
                wr_tlb   = 1'b1;
            end
            FT_SYSCALL: code = 5'd8;
            FT_BREAK:   code = 5'd9;
            FT_RSVD:    code = 5'd10;
            FT_COP_UNU: begin
                code  = 5'd11;
                wr_ce = 1'b1;
            end
            FT_OVFL:    code = 5'd12;
            FT_TRAP:    code = 5'd13;
            FT_MCHK:    code = 5'd24;
            FT_THREAD:  code = 5'd25;
            FT_IBUS:    code = 5'd6;
            FT_DBUS:    code = 5'd7;
            FT_WATCH:   code = 5'd23;
            default:    code = 5'd0;
        endcase
    end

endmodule

// File: rtl/cp0_exc_vector.sv
module cp0_exc_vector
    import cp0_exc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              bev,
    input  logic [ADDR_W-1:0] ebase,
    input  logic              iv,
    input  logic              exl,
    input  ofs_class_e        ofs_class,
    output logic [ADDR_W-1:0] vec
);
    localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'(32'hBFC0_0200);
    localparam logic [ADDR_W-1:0] OFS_GEN   = ADDR_W'(12'h180);
    localparam logic [ADDR_W-1:0] OFS_IV    = ADDR_W'(12'h200);
    localparam logic [ADDR_W-1:0] OFS_ZERO  = '0;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] ofs;

    always_comb begin
        base = bev ? BOOT_BASE : ebase;
        unique case (ofs_class)
            OFS_INTR:   ofs = iv  ? OFS_IV  : OFS_GEN;
            OFS_REFILL: ofs = exl ? OFS_GEN : OFS_ZERO;
            default:    ofs = OFS_GEN;
        endcase
        vec = base + ofs;
    end

endmodule

// File: rtl/cp0_exc_entry.sv
module cp0_exc_entry
    import cp0_exc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int ASID_W = 8,
    parameter int VPN_W  = 21,
    parameter int CP_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [3:0]          req_type,
    input  logic                req_store,
    input  logic [ADDR_W-1:0]   req_vaddr,
    input  logic [ADDR_W-1:0]   req_pc,
    input  logic [ASID_W-1:0]   req_asid,
    input  logic [VPN_W-1:0]    req_vpn,
    input  logic [CP_W-1:0]     req_cop,
    input  logic                cfg_bev,
    input  logic [ADDR_W-1:0]   cfg_ebase,
    input  logic                cfg_iv,
    output logic                redirect_valid,
    output logic [ADDR_W-1:0]   redirect_vec,
    output logic [ADDR_W-1:0]   badvaddr,
    output logic [ASID_W-1:0]   entryhi_asid,
    output logic [VPN_W-3:0]    entryhi_vpn2,
    output logic [1:0]          entryhi_vpn2x,
    output logic [VPN_W-3:0]    context_badvpn2,
    output logic [CODE_W-1:0]   cause_exccode,
    output logic [CP_W-1:0]     cause_ce,
    output logic                status_exl,
    output logic [ADDR_W-1:0]   epc
);
    localparam int VPN2_W = VPN_W - 2;

    typedef struct packed {
        logic                redir_vld;
        logic [ADDR_W-1:0]   redir_vec;
        logic [ADDR_W-1:0]   badva;
        logic [ASID_W-1:0]   asid;
        logic [VPN2_W-1:0]   vpn2;
        logic [1:0]          vpn2x;
        logic [VPN2_W-1:0]   ctx_vpn2;
        logic [CODE_W-1:0]   exccode;
        logic [CP_W-1:0]     ce;
        logic                exl;
        logic [ADDR_W-1:0]   epc;
    } state_t;

    state_t s_d, s_q;

    logic [CODE_W-1:0] dec_code;
    ofs_class_e        dec_ofs;
    logic              dec_badva;
    logic              dec_tlb;
    logic              dec_ce;
    logic [ADDR_W-1:0] vec;

    cp0_exc_decode u_dec (
        .fault_type (req_type),
        .is_store   (req_store),
        .code       (dec_code),
        .ofs_class  (dec_ofs),
        .wr_badva   (dec_badva),
        .wr_tlb     (dec_tlb),
        .wr_ce      (dec_ce)
    );

    cp0_exc_vector #(.ADDR_W(ADDR_W)) u_vec (
        .bev       (cfg_bev),
        .ebase     (cfg_ebase),
        .iv        (cfg_iv),
        .exl       (s_q.exl),
        .ofs_class (dec_ofs),
        .vec       (vec)
    );

    always_comb begin
        s_d           = s_q;
        s_d.redir_vld = 1'b0;
        if (req_valid) begin
            s_d.redir_vld = 1'b1;
            s_d.redir_vec = vec;
            s_d.exccode   = dec_code;
            s_d.exl       = 1'b1;
            s_d.epc       = req_pc;
            if (dec_badva) begin
                s_d.badva = req_vaddr;
            end
            if (dec_tlb) begin
                s_d.asid     = req_asid;
                s_d.vpn2     = req_vpn[VPN_W-1:2];
                s_d.vpn2x    = req_vpn[1:0];
                s_d.ctx_vpn2 = req_vpn[VPN_W-1:2];
            end
            if (dec_ce) begin
                s_d.ce = req_cop;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign redirect_valid  = s_q.redir_vld;
    assign redirect_vec    = s_q.redir_vec;
    assign badvaddr        = s_q.badva;
    assign entryhi_asid    = s_q.asid;
    assign entryhi_vpn2    = s_q.vpn2;
    assign entryhi_vpn2x   = s_q.vpn2x;
    assign context_badvpn2 = s_q.ctx_vpn2;
    assign cause_exccode   = s_q.exccode;
    assign cause_ce        = s_q.ce;
    assign status_exl      = s_q.exl;
    assign epc             = s_q.epc;

endmodule

// File: rtl/cp0_exc_entry_chk.sv
module cp0_exc_entry_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [3:0]        req_type,
    input logic [ADDR_W-1:0] req_pc,
    input logic              cfg_bev,
    input logic              cfg_iv,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_vec,
    input logic [ADDR_W-1:0] badvaddr,
    input logic [4:0]        cause_exccode,
    input logic              status_exl,
    input logic [ADDR_W-1:0] epc
);
    // R11
    redir_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> redirect_valid);

    // R11
    redir_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !redirect_valid);

    // R11
    exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> status_exl);

    // R11
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (epc == $past(req_pc)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(badvaddr) && $stable(epc) && $stable(cause_exccode)));

    // R7
    tlbmod_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == 4'd4) |=> (cause_exccode == 5'd1));

    // R3
    intr_iv_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == 4'd0 && cfg_bev && cfg_iv)
        |=> (redirect_vec == ADDR_W'(32'hBFC0_0400)));

endmodule

bind cp0_exc_entry cp0_exc_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_type       (req_type),
    .req_pc         (req_pc),
    .cfg_bev        (cfg_bev),
    .cfg_iv         (cfg_iv),
    .redirect_valid (redirect_valid),
    .redirect_vec   (redirect_vec),
    .badvaddr       (badvaddr),
    .cause_exccode  (cause_exccode),
    .status_exl     (status_exl),
    .epc            (epc)
);

// File: tb/sim_cp0_exc_entry.sv
`timescale 1ns/1ps
module sim_cp0_exc_entry;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_type = '0;
    logic        req_store = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_pc = '0;
    logic [7:0]  req_asid = '0;
    logic [20:0] req_vpn = '0;
    logic [1:0]  req_cop = '0;
    logic        cfg_bev = 1'b1;
    logic [31:0] cfg_ebase = '0;
    logic        cfg_iv = 1'b0;
    logic        redirect_valid;
    logic [31:0] redirect_vec;
    logic [31:0] badvaddr;
    logic [7:0]  entryhi_asid;
    logic [18:0] entryhi_vpn2;
    logic [1:0]  entryhi_vpn2x;
    logic [18:0] context_badvpn2;
    logic [4:0]  cause_exccode;
    logic [1:0]  cause_ce;
    logic        status_exl;
    logic [31:0] epc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    cp0_exc_entry u0 (.*);

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_code(input int t, input logic st);
        case (t)
            0: return 5'd0;   1: return st ? 5'd5 : 5'd4;
            2: return st ? 5'd3 : 5'd2;   3: return st ? 5'd3 : 5'd2;
            4: return 5'd1;   5: return 5'd8;   6: return 5'd9;
            7: return 5'd10;  8: return 5'd11;  9: return 5'd12;
            10: return 5'd13; 11: return 5'd24; 12: return 5'd25;
            13: return 5'd6;  14: return 5'd7;  default: return 5'd23;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive at a falling edge, sample at the falling edge after the accepting rise
    task automatic do_req(input int t, input logic st, input logic [31:0] va,
                          input logic [31:0] pc, input logic [7:0] asid,
                          input logic [20:0] vpn, input logic [1:0] cop);
        req_valid = 1'b1;
        req_type  = 4'(t);
        req_store = st;
        req_vaddr = va;
        req_pc    = pc;
        req_asid  = asid;
        req_vpn   = vpn;
        req_cop   = cop;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 redirect", {31'd0, redirect_valid}, 32'd0);
        chk("R1 exl", {31'd0, status_exl}, 32'd0);
        chk("R1 badvaddr", badvaddr, 32'd0);
        chk("R1 epc", epc, 32'd0);
        chk("R1 code", {27'd0, cause_exccode}, 32'd0);
        chk("R1 vpn2", {13'd0, entryhi_vpn2}, 32'd0);
    endtask

    task automatic t_codes();
        for (int t = 0; t < 16; t++) begin
            for (int s = 0; s < 2; s++) begin
                logic [31:0] ofs;
                do_reset();
                cfg_bev = 1'b1;
                cfg_iv  = 1'b0;
                do_req(t, s[0], 32'h0, 32'h100 + 32'(t), 8'h0, 21'h0, 2'd0);
                ofs = (t == 2) ? 32'h0 : 32'h180;
                chk("R6 R7 code", {27'd0, cause_exccode}, {27'd0, exp_code(t, s[0])});
                chk("R5 R4 R3 vector", redirect_vec, 32'hBFC0_0200 + ofs);
                chk("R11 pulse", {31'd0, redirect_valid}, 32'd1);
                chk("R11 exl", {31'd0, status_exl}, 32'd1);
                chk("R11 epc", epc, 32'h100 + 32'(t));
                @(negedge clk);
                chk("R11 pulse ends", {31'd0, redirect_valid}, 32'd0);
            end
        end
    endtask

    task automatic t_base();
        do_reset();
        cfg_bev = 1'b0;
        cfg_ebase = 32'h8000_1000;
        do_req(5, 1'b0, 32'h0, 32'h4, 8'h0, 21'h0, 2'd0);
        chk("R2 ebase vector", redirect_vec, 32'h8000_1180);
        do_req(2, 1'b0, 32'h0, 32'h8, 8'h0, 21'h0, 2'd0);
        chk("R2 R4 ebase refill in exl", redirect_vec, 32'h8000_1180);
        do_reset();
        do_req(2, 1'b0, 32'h0, 32'h8, 8'h0, 21'h0, 2'd0);
        chk("R2 R4 ebase refill", redirect_vec, 32'h8000_1000);
        cfg_bev = 1'b1;
        do_req(6, 1'b0, 32'h0, 32'hC, 8'h0, 21'h0, 2'd0);
        chk("R2 boot vector", redirect_vec, 32'hBFC0_0380);
    endtask

    task automatic t_intr();
        do_reset();
        cfg_iv = 1'b1;
        do_req(0, 1'b0, 32'h0, 32'h10, 8'h0, 21'h0, 2'd0);
        chk("R3 iv=1", redirect_vec, 32'hBFC0_0400);
        cfg_iv = 1'b0;
        do_req(0, 1'b0, 32'h0, 32'h14, 8'h0, 21'h0, 2'd0);
        chk("R3 iv=0", redirect_vec, 32'hBFC0_0380);
    endtask

    task automatic t_refill_exl();
        do_reset();
        do_req(2, 1'b0, 32'h0, 32'h20, 8'h0, 21'h0, 2'd0);
        chk("R4 exl=0", redirect_vec, 32'hBFC0_0200);
        chk("R7 refill load", {27'd0, cause_exccode}, 32'd2);
        // back-to-back: second request sees EXL set by the first
        req_valid = 1'b1; req_type = 4'd2; req_store = 1'b1;
        @(negedge clk);
        req_type = 4'd3;
        chk("R4 exl=1", redirect_vec, 32'hBFC0_0380);
        chk("R7 refill store", {27'd0, cause_exccode}, 32'd3);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 back-to-back pulse", {31'd0, redirect_valid}, 32'd1);
        chk("R5 invalid vector", redirect_vec, 32'hBFC0_0380);
    endtask

    task automatic t_tlb_regs();
        do_reset();
        do_req(3, 1'b1, 32'h1234_5000, 32'h30, 8'h5A, 21'h1ABCD, 2'd0);
        chk("R8 badvaddr", badvaddr, 32'h1234_5000);
        chk("R9 asid", {24'd0, entryhi_asid}, 32'h5A);
        chk("R9 vpn2", {13'd0, entryhi_vpn2}, 32'h1ABCD >> 2);
        chk("R9 vpn2x", {30'd0, entryhi_vpn2x}, 32'h1);
        chk("R9 context", {13'd0, context_badvpn2}, 32'h1ABCD >> 2);
        do_req(5, 1'b0, 32'hDEAD_BEEF, 32'h34, 8'h11, 21'h00FF2, 2'd3);
        chk("R8 syscall keeps badvaddr", badvaddr, 32'h1234_5000);
        chk("R9 syscall keeps asid", {24'd0, entryhi_asid}, 32'h5A);
        chk("R9 syscall keeps context", {13'd0, context_badvpn2}, 32'h1ABCD >> 2);
        chk("R10 syscall keeps ce", {30'd0, cause_ce}, 32'd0);
        do_req(4, 1'b0, 32'h0000_7777, 32'h38, 8'h22, 21'h00006, 2'd0);
        chk("R7 mod load code", {27'd0, cause_exccode}, 32'd1);
        chk("R9 mod vpn2x", {30'd0, entryhi_vpn2x}, 32'h2);
        chk("R9 mod asid", {24'd0, entryhi_asid}, 32'h22);
        do_req(1, 1'b1, 32'hA000_0003, 32'h3C, 8'h99, 21'h1FFFF, 2'd0);
        chk("R8 addr err badvaddr", badvaddr, 32'hA000_0003);
        chk("R9 addr err keeps asid", {24'd0, entryhi_asid}, 32'h22);
        chk("R9 addr err keeps vpn2", {13'd0, entryhi_vpn2}, 32'h1);
    endtask

    task automatic t_cop();
        do_reset();
        do_req(8, 1'b0, 32'h0, 32'h40, 8'h0, 21'h0, 2'd2);
        chk("R10 ce", {30'd0, cause_ce}, 32'd2);
        chk("R6 cpu code", {27'd0, cause_exccode}, 32'd11);
        do_req(9, 1'b0, 32'h0, 32'h44, 8'h0, 21'h0, 2'd3);
        chk("R10 overflow keeps ce", {30'd0, cause_ce}, 32'd2);
        chk("R8 overflow keeps badvaddr", badvaddr, 32'd0);
    endtask

    task automatic t_idle();
        do_reset();
        do_req(2, 1'b0, 32'h5555_0000, 32'h50, 8'h3, 21'h3, 2'd0);
        req_vaddr = 32'hFFFF_FFFF; req_pc = 32'hFFFF_FFFF; req_type = 4'd1;
        repeat (3) @(negedge clk);
        chk("R12 idle redirect", {31'd0, redirect_valid}, 32'd0);
        chk("R12 idle badvaddr", badvaddr, 32'h5555_0000);
        chk("R12 idle epc", epc, 32'h50);
        chk("R12 idle code", {27'd0, cause_exccode}, 32'd2);
    endtask

    initial begin
        t_reset();
        t_codes();
        t_base();
        t_intr();
        t_refill_exl();
        t_tlb_regs();
        t_cop();
        t_idle();
        finish_run();
    end

endmodule